// File: doc/BRIEF.md
# Tree-Structured 16:1 Serializer

This block turns a 16-bit parallel word into a single serial bit stream running at sixteen times the word rate. A shift-register front end splits each word into four lanes that run at one quarter of the serial rate. A two-level binary tree of 2:1 nodes then merges those lanes into one stream. Each node captures its first input through a two-stage leg and its second input through a three-stage leg, so the two legs sit half a slot apart, and a phase select alternates between them.

The whole block runs on one fast clock at the serial bit rate. A free-running phase counter produces the enables that stand in for the half-rate, quarter-rate and word-rate clocks. The block tells the sender when a word is taken by raising `word_strobe` for one fast cycle. The word on `word_in` is captured at the end of that cycle. Words are expected back to back, and the serial stream has no gap between them. The serial output is driven as a true and complement pair.

Top module: `ser16_tree`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `serial_p` = 0, `serial_n` = 1 and `word_strobe` = 0.
- R2: After reset is released, `word_strobe` is high for exactly one cycle in every 16. The first pulse falls in the 16th cycle, counting the first cycle with `rst_n` high as cycle 1.
- R3: The word present on `word_in` during a `word_strobe` cycle is captured at the end of that cycle. Its bit 0 appears on `serial_p` exactly 5 cycles after the strobe cycle.
- R4: Bits leave least significant first. Bit i of a captured word appears on `serial_p` 5 + i cycles after its strobe cycle, for i = 0..15.
- R5: Consecutive words stream without a gap: the cycle after bit 15 of one word carries bit 0 of the next word.
- R6: `serial_n` is the complement of `serial_p` in every cycle.
- R7: A value on `word_in` during a cycle without `word_strobe` has no effect on the serial stream.
- R8: After reset, `serial_p` stays 0 until the first bit of the first captured word is due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at the serial bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | 16 | Parallel word, sampled at the end of a strobe cycle |
| word_strobe | output | 1 | High in the cycle whose end captures `word_in` |
| serial_p | output | 1 | Serial data, LSB of each word first |
| serial_n | output | 1 | Complement of `serial_p` |

## Verification
The embedded assertions watch the framing on every cycle. They check that the reset state is forced, that the strobe is a single-cycle pulse lined up with a lane slot boundary, that each lane's first bit is the matching word bit just captured, that a tree node's output changes only when its phase select flips, and that the two serial outputs stay complementary. Whether the tree rebuilds the exact LSB-first order, with the stated five-cycle latency and no gap at the join between words, can only be shown by the bench. The bench streams random words, drives junk on `word_in` between strobes, and compares every serial bit against a behavioural model. It also applies a reset in the middle of a run to check that the output restarts from a clean frame.

// File: rtl/ser16_pkg.sv
// Package: shared constants for the tree serializer.
// Assumes a four-lane front end feeding a two-level 2:1 tree.
package ser16_pkg;
    localparam int WORD_W  = 16;               // parallel word width
    localparam int LANES   = 4;                // lanes out of the front end
    localparam int DEPTH   = WORD_W / LANES;   // bits held per lane
    localparam int PHASE_W = $clog2(WORD_W);   // phase counter width
    localparam int LATENCY = 5;                // strobe cycle to bit 0 on output
endpackage

// File: rtl/ser16_phase.sv
// Module: phase generator. A free-running counter over one word period
// produces the enables that replace the slower rate clocks.
// Assumes PHASE_W >= 2 and a word period that is a power of two.
module ser16_phase #(
    parameter int PHASE_W = ser16_pkg::PHASE_W
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_en,     // last cycle of a word period
    output logic slot_end,    // last cycle of a quarter-rate slot
    output logic slot_mid,    // second cycle of a quarter-rate slot
    output logic half_sel,    // high during the second half of a slot
    output logic bit_sel      // high on odd fast cycles
);
    logic [PHASE_W-1:0] phase;

    // Count fast cycles within the word period.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    assign load_en  = &phase;
    assign slot_end = (phase[1:0] == 2'd3);
    assign slot_mid = (phase[1:0] == 2'd1);
    assign half_sel = phase[1];
    assign bit_sel  = phase[0];

    // The strobe never lasts two cycles.
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en);
    // A word load always coincides with the end of a lane slot.
    assert_strobe_on_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> slot_end);
endmodule

// File: rtl/ser16_lane_bank.sv
// Module: front end. It splits the word into interleaved lanes and
// shifts each lane out LSB first once per slot.
// Lane k holds bits k, k+LANES, k+2*LANES and so on, so a tree that
// visits the lanes in order rebuilds strict LSB-first order.
module ser16_lane_bank #(
    parameter int WORD_W = ser16_pkg::WORD_W,
    parameter int LANES  = ser16_pkg::LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] word,
    output logic [LANES-1:0]  lane_bit
);
    localparam int DEPTH = WORD_W / LANES;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [DEPTH-1:0] sr;

        // Load the lane's interleaved bits, or shift toward the output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sr <= '0;
            end else if (load_en) begin
                for (int d = 0; d < DEPTH; d++) sr[d] <= word[k + LANES*d];
            end else if (shift_en) begin
                sr <= {1'b0, sr[DEPTH-1:1]};
            end
        end

        assign lane_bit[k] = sr[0];

        // Right after a load, each lane presents its lowest word bit.
        assert_lane_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
            load_en |=> lane_bit[k] == $past(word[k]));
    end
endmodule

// File: rtl/ser16_mux_node.sv
// Module: one 2:1 tree node. Leg a is captured once per input slot by a
// two-stage register. Leg b takes the same capture and then one more
// half-slot stage, so b lags a by half a slot. The phase select then
// alternates between the aligned legs.
// Assumes cap_en and late_en are half an input slot apart and that sel
// flips on the cycle after each of them.
module ser16_mux_node (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic late_en,
    input  logic sel,
    input  logic a,
    input  logic b,
    output logic y
);
    logic a_q, b_q, b_late;

    // Capture both legs mid-slot while their inputs are stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else if (cap_en) begin
            a_q <= a;
            b_q <= b;
        end
    end

    // Third stage on leg b: move it half a slot later.
    always_ff @(posedge clk) begin
        if (!rst_n)       b_late <= 1'b0;
        else if (late_en) b_late <= b_q;
    end

    assign y = sel ? a_q : b_late;

    // The node output only moves when the select changes phase (R4 ordering).
    assert_node_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == $past(sel)) |-> $stable(y));
endmodule

// File: rtl/ser16_tree.sv
// Module: top of the 16:1 serializer. A lane bank feeds a two-level
// tree of 2:1 nodes, and a final register drives the complementary pair.
// Assumes a single fast clock at the bit rate and back-to-back words.
module ser16_tree #(
    parameter int WORD_W = ser16_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_strobe,
    output logic              serial_p,
    output logic              serial_n
);
    localparam int LANES   = ser16_pkg::LANES;
    localparam int PHASE_W = $clog2(WORD_W);

    logic             load_en, slot_end, slot_mid, half_sel, bit_sel;
    logic [LANES-1:0] lane_bit;
    logic             even_y, odd_y, root_y;

    ser16_phase #(.PHASE_W(PHASE_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .slot_end(slot_end),
        .slot_mid(slot_mid), .half_sel(half_sel), .bit_sel(bit_sel)
    );

    ser16_lane_bank #(.WORD_W(WORD_W), .LANES(LANES)) u_lanes (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(slot_end),
        .word(word_in), .lane_bit(lane_bit)
    );

    // First level: lanes 0 and 2 form the even half-rate stream.
    ser16_mux_node u_node_even (
        .clk(clk), .rst_n(rst_n), .cap_en(slot_mid), .late_en(slot_end),
        .sel(half_sel), .a(lane_bit[0]), .b(lane_bit[2]), .y(even_y)
    );

    // First level: lanes 1 and 3 form the odd half-rate stream.
    ser16_mux_node u_node_odd (
        .clk(clk), .rst_n(rst_n), .cap_en(slot_mid), .late_en(slot_end),
        .sel(half_sel), .a(lane_bit[1]), .b(lane_bit[3]), .y(odd_y)
    );

    // Second level: interleave the two streams at the full bit rate.
    ser16_mux_node u_node_root (
        .clk(clk), .rst_n(rst_n), .cap_en(!bit_sel), .late_en(bit_sel),
        .sel(bit_sel), .a(even_y), .b(odd_y), .y(root_y)
    );

    // Output flip-flop pair drives true and complement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serial_p <= 1'b0;
            serial_n <= 1'b1;
        end else begin
            serial_p <= root_y;
            serial_n <= ~root_y;
        end
    end

    assign word_strobe = load_en;

    // Reset forces an idle, framed state on the next cycle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!serial_p && serial_n && !word_strobe));
    // The output pair never agrees.
    assert_pair_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        serial_n == ~serial_p);
endmodule

// File: tb/ser16_tree_test.sv
// Bench: behavioural model of the serial stream, compared every cycle.
module ser16_tree_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] word_in = '0;
    logic        word_strobe, serial_p, serial_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ser16_tree uut (
        .clk(clk), .rst_n(rst_n), .word_in(word_in),
        .word_strobe(word_strobe), .serial_p(serial_p), .serial_n(serial_n)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int actual, input int expected, input int cyc);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, actual, expected);
        end
    endtask

    // Expected serial bit and its position, keyed by cycle index.
    bit exp_bit[int];
    int exp_pos[int];

    initial begin
        bit applied;
        int since;
        int words;
        since = 0;
        words = 0;
        for (int n = 0; n < 2400; n++) begin
            bit drive_rst;
            @(negedge clk);
            applied = !rst_n;   // level seen at the edge just passed
            if (applied) begin
                since = 0;
                exp_bit.delete();
                exp_pos.delete();
                check("R1 serial_p", serial_p, 0, n);
                check("R1 serial_n", serial_n, 1, n);
                check("R1 strobe", word_strobe, 0, n);
            end else begin
                since++;
                // R2: one pulse per 16 cycles, first in cycle 16 after release.
                check("R2 strobe", word_strobe, (since % 16 == 15) ? 1 : 0, n);
                check("R6 complement", serial_n, serial_p ? 0 : 1, n);
                if (exp_bit.exists(n)) begin
                    string tag;
                    if (exp_pos[n] == 0)       tag = "R3 first bit";
                    else if (exp_pos[n] == 15) tag = "R5 last bit";
                    else                       tag = "R4 R7 bit order";
                    check(tag, serial_p, exp_bit[n], n);
                end else begin
                    check("R8 idle low", serial_p, 0, n);
                end
            end
            // Schedule: reset at start and again in the middle of the run.
            drive_rst = (n < 4) || (n >= 1200 && n < 1204);
            rst_n = !drive_rst;
            // Drive a real word in strobe cycles and junk otherwise (R7).
            word_in = 16'($urandom);
            if (word_strobe && !applied && !drive_rst) begin
                words++;
                for (int i = 0; i < 16; i++) begin
                    exp_bit[n + 5 + i] = word_in[i];
                    exp_pos[n + 5 + i] = i;
                end
            end
        end
        check("R3 words sent", (words > 100) ? 1 : 0, 1, 2400);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule